// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous memory of 36-bit words that avoids any bus turnaround penalty. A command, its address and its byte-lane enables are captured on one rising clock edge. Read data is returned on the data bus during the cycle that ends at the second edge after the command. Write data is taken from the bus at that same second edge. Because both directions use the bus in the same slot, reads and writes can follow each other in any order at full rate.

Write data arrives two cycles after its command, so the array is updated late. A read issued one or two cycles after a write to the same word would otherwise see stale contents. A bypass path merges the pending bytes into the read result. A burst mode steps the two low address bits with an internal counter, in either linear or XOR order. An active-high hold input freezes the whole pipeline for that cycle.

Top module: `lw_sram`

## Requirements
- R1: A read command registered at a non-held edge k presents the addressed word on `d_out` with `d_oe` high for the cycle between edge k+1 and edge k+2 (edges counted over non-held edges).
- R2: For a write command registered at edge k, `d_in` is sampled at edge k+2. The lane enables are taken at edge k together with the command.
- R3: Any mix of reads, writes and deselects issued on consecutive edges executes with no idle cycles. Each read returns the word left by all earlier writes in command order.
- R4: With `burst_next` low, the cycle is a deselect when `sel_a_n` is high, `sel_b` is low or `sel_c_n` is high. Operations already issued still complete. `d_oe` is low for the output slot of a deselect.
- R5: While `hold` is high, no register changes, including the pipeline, the burst counter and the array. `d_out` keeps its value, and data on `d_in` is not sampled.
- R6: With `burst_next` high, `addr`, `rd_not_wr` and the select inputs are ignored. The cycle repeats the previous operation type (read, write or deselect) at the next counter address. Lane enables are still taken on burst writes.
- R7: The upper address bits of a burst stay fixed and only the two low bits change. For the n-th step after a load at low bits s, the low bits are (s+n) mod 4 when `order_xor` is low and s XOR n when it is high.
- R8: `lane_wr_n[i]` is active low and guards bits 9i+8..9i of the word. A lane whose enable is high keeps its previous contents.
- R9: `d_oe` is low whenever `out_en_n` is high, and this acts combinationally within the same cycle. `out_en_n` has no effect on writes.
- R10: A read that targets a word with a write still pending (its command issued one or two edges earlier) returns the pending enabled lanes merged over the stored word. The newer write wins where two such writes overlap.
- R11: `d_oe` is never high in a cycle whose closing edge samples write data.
- R12: After synchronous reset, no operation is pending, `d_oe` is low and the burst state is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | High stalls every register for the cycle |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | High: continue burst; low: load new command |
| rd_not_wr | input | 1 | High: read; low: write (on load cycles) |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | 4 | Per-lane write inhibit, active low enable |
| order_xor | input | 1 | Burst order: low linear, high XOR |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | 36 | Data bus, inbound half |
| d_out | output | 36 | Data bus, outbound half |
| d_oe | output | 1 | Drive enable for the outbound half |

## Verification
The assertions rely on a few properties of the inputs. Reset is held for at least one edge before any traffic starts. `out_en_n` settles before the sampling edge. `order_xor` does not change in the middle of a burst the checks depend on. The stimulus drives every input just after the falling edge. It keeps `order_xor` fixed within each burst group and writes every address once before any read, so no read result depends on uninitialised storage. During burst and held cycles, the address, select and data inputs are deliberately filled with junk values, and the results are still required to come out correct.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  // take lanes of 'fresh' whose inhibit bit is low, keep the rest of 'base'
  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] base,
    input logic [WORD_W-1:0] fresh,
    input logic [LANES-1:0]  inhibit_n);
    logic [WORD_W-1:0] r;
    r = base;
    for (int i = 0; i < LANES; i++)
      if (!inhibit_n[i]) r[i*LANE_W +: LANE_W] = fresh[i*LANE_W +: LANE_W];
    return r;
  endfunction

  function automatic logic [1:0] burst_low(
    input logic [1:0] start,
    input logic [1:0] step,
    input logic       xor_mode);
    return xor_mode ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_next,
  input  logic              rd_not_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_xor,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);
  op_e               last_op;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q, step_d;

  always_comb begin
    if (burst_next) begin
      step_d   = step_q + 2'd1;
      cmd_op   = last_op;
      cmd_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_d, order_xor)};
    end else begin
      step_d   = 2'd0;
      cmd_addr = addr;
      if (sel_a_n || !sel_b || sel_c_n) cmd_op = OP_IDLE;
      else if (rd_not_wr)               cmd_op = OP_RD;
      else                              cmd_op = OP_WR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_op <= OP_IDLE;
      step_q  <= 2'd0;
      base_q  <= '0;
    end else if (!hold) begin
      last_op <= cmd_op;
      step_q  <= step_d;
      if (!burst_next) base_q <= addr;
    end
  end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6
)(
  input  logic              clk,
  input  logic              en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_q,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_lane_n
);
  localparam int DEPTH = 1 << ADDR_W;

  // one narrow memory per lane: read-first, clock-enabled, block RAM friendly
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (en) begin
        if (we && !wr_lane_n[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        rd_q[g*LANE_W +: LANE_W] <= mem[rd_addr];
      end
    end
  end
endmodule

// File: rtl/lw_sram_fwd.sv
module lw_sram_fwd
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6
)(
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] ram_word,
  input  logic              old_vld,
  input  logic [ADDR_W-1:0] old_addr,
  input  logic [LANES-1:0]  old_lane_n,
  input  logic [WORD_W-1:0] old_data,
  input  logic              new_vld,
  input  logic [ADDR_W-1:0] new_addr,
  input  logic [LANES-1:0]  new_lane_n,
  input  logic [WORD_W-1:0] new_data,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] mid;
  always_comb begin
    mid  = (old_vld && old_addr == rd_addr) ? lane_merge(ram_word, old_data, old_lane_n) : ram_word;
    word = (new_vld && new_addr == rd_addr) ? lane_merge(mid, new_data, new_lane_n) : mid;
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_next,
  input  logic              rd_not_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        lane_wr_n,
  input  logic              order_xor,
  input  logic              out_en_n,
  input  logic [35:0]       d_in,
  output logic [35:0]       d_out,
  output logic              d_oe
);
  op_e               cmd_op, s1_op, s2_op;
  logic [ADDR_W-1:0] cmd_addr, s1_addr, s2_addr, wb_addr;
  logic [LANES-1:0]  s1_lane, s2_lane, wb_lane;
  logic [WORD_W-1:0] ram_word, fwd_word, wb_data, out_q;
  logic              wb_vld, out_vld, wr_due;

  lw_sram_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk, .rst, .hold, .sel_a_n, .sel_b, .sel_c_n, .burst_next, .rd_not_wr,
    .addr, .order_xor, .cmd_op, .cmd_addr);

  assign wr_due = (s2_op == OP_WR);

  lw_sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk, .en(!hold), .rd_addr(cmd_addr), .rd_q(ram_word),
    .we(wr_due && !rst), .wr_addr(s2_addr), .wr_data(d_in), .wr_lane_n(s2_lane));

  // older write already in the array one edge too late for the read; newer write on d_in now
  lw_sram_fwd #(.ADDR_W(ADDR_W)) u_fwd (
    .rd_addr(s1_addr), .ram_word,
    .old_vld(wb_vld), .old_addr(wb_addr), .old_lane_n(wb_lane), .old_data(wb_data),
    .new_vld(wr_due), .new_addr(s2_addr), .new_lane_n(s2_lane), .new_data(d_in),
    .word(fwd_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_IDLE;
      s2_op   <= OP_IDLE;
      wb_vld  <= 1'b0;
      out_vld <= 1'b0;
    end else if (!hold) begin
      s1_op   <= cmd_op;
      s2_op   <= s1_op;
      wb_vld  <= wr_due;
      out_vld <= (s1_op == OP_RD);
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) begin
      s1_addr <= cmd_addr;
      s1_lane <= lane_wr_n;
      s2_addr <= s1_addr;
      s2_lane <= s1_lane;
      wb_addr <= s2_addr;
      wb_lane <= s2_lane;
      wb_data <= d_in;
      out_q   <= fwd_word;
    end
  end

  assign d_out = out_q;
  assign d_oe  = out_vld && !out_en_n;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
  input logic        clk,
  input logic        rst,
  input logic        hold,
  input logic        burst_next,
  input logic        sel_a_n,
  input logic        sel_b,
  input logic        sel_c_n,
  input logic        out_en_n,
  input logic        wr_due,
  input logic        d_oe,
  input logic [35:0] d_out
);
  // R4: a deselect load leaves the output slot undriven one active edge later
  a_r4_deselect_hiz: assert property (@(posedge clk) disable iff (rst)
    (!hold && !burst_next && (sel_a_n || !sel_b || sel_c_n)) ##1 !hold |=> !d_oe);

  // R5: a held edge keeps the output register
  a_r5_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(d_out));

  // R9: output enable gates the drivers
  a_r9_oe_gate: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !d_oe);

  // R11: never drive while write data is due
  a_r11_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
    wr_due |-> !d_oe);
endmodule

bind lw_sram lw_sram_chk u_chk (
  .clk(clk), .rst(rst), .hold(hold), .burst_next(burst_next),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .out_en_n(out_en_n),
  .wr_due(wr_due), .d_oe(d_oe), .d_out(d_out));

// File: tb/lw_sram_test.sv
`timescale 1ns/1ps
module lw_sram_test;
  localparam int AW   = 6;
  localparam int NW   = 1 << AW;
  localparam int MAXE = 1200;

  logic clk = 1'b0, rst = 1'b1, hold = 1'b0;
  logic sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic burst_next = 1'b0, rd_not_wr = 1'b1, order_xor = 1'b0, out_en_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0]    lane_wr_n = 4'h0;
  logic [35:0]   d_in = '0, d_out;
  logic          d_oe;

  always #2.5 clk = ~clk;

  lw_sram #(.ADDR_W(AW)) uut (.*);

  int checks = 0, fails = 0;
  logic [31:0] lf = 32'h1234_5678;

  // entry list (one per clock) and command list (one per non-held edge)
  bit          e_stall [MAXE];
  bit          e_oen   [MAXE];
  bit          e_ord   [MAXE];
  int          e_kind  [MAXE];   // 0 deselect, 1 read, 2 write, 3 burst
  int          e_addr  [MAXE];
  int          e_dp    [MAXE];
  logic [3:0]  e_lane  [MAXE];
  bit          c_isrd  [MAXE];
  bit          c_iswr  [MAXE];
  logic [35:0] c_wd    [MAXE];
  logic [35:0] c_exp   [MAXE];
  string       c_tag   [MAXE];
  int ne = 0, nc = 0, seed = 1;
  bit g_oen = 0, g_ord = 0;
  logic [35:0] ref_m [NW];
  int b_op = 0, b_base = 0, b_n = 0;

  function automatic logic [31:0] rnd();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    return lf;
  endfunction

  function automatic logic [35:0] pat(int s);
    logic [31:0] m = 32'(s) * 32'h9E37_79B1;
    return {4'(s) ^ 4'hA, m};
  endfunction

  task automatic fail(string tag, string what, logic [35:0] act, logic [35:0] exp);
    fails++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  // resolve one command in program order against the bench's own memory
  task automatic add(int kind, int a, logic [3:0] ln, string tag, int dp = 0);
    int op, ea;
    e_stall[ne] = 0; e_oen[ne] = g_oen; e_ord[ne] = g_ord; e_kind[ne] = kind;
    e_addr[ne] = a; e_lane[ne] = ln; e_dp[ne] = dp;
    if (kind == 3) begin
      b_n = (b_n + 1) % 4;
      op = b_op;
      ea = (b_base & ~3) | (g_ord ? ((b_base & 3) ^ b_n) : (((b_base & 3) + b_n) % 4));
    end else begin
      op = kind; ea = a; b_op = kind; b_base = a; b_n = 0;
    end
    c_isrd[nc] = (op == 1); c_iswr[nc] = (op == 2);
    c_wd[nc] = pat(seed++); c_tag[nc] = tag;
    if (op == 1) c_exp[nc] = ref_m[ea];
    if (op == 2)
      for (int i = 0; i < 4; i++)
        if (!ln[i]) ref_m[ea][i*9 +: 9] = c_wd[nc][i*9 +: 9];
    ne++; nc++;
  endtask

  task automatic add_stall();
    e_stall[ne] = 1; e_oen[ne] = g_oen; e_ord[ne] = g_ord; e_kind[ne] = 0;
    e_addr[ne] = 0; e_lane[ne] = 4'h0; e_dp[ne] = 0; ne++;
  endtask

  task automatic run();
    int k = 0;   // non-held edges before the current entry
    for (int e = 0; e < ne; e++) begin
      @(negedge clk);
      hold = e_stall[e]; out_en_n = e_oen[e]; order_xor = e_ord[e];
      lane_wr_n = e_lane[e];
      burst_next = (e_kind[e] == 3);
      if (e_stall[e] || e_kind[e] == 3) begin   // junk on ignored inputs (R6, R5)
        {sel_a_n, sel_b, sel_c_n, rd_not_wr} = 4'(rnd());
        addr = AW'(rnd());
        if (e_stall[e]) burst_next = rnd() & 1;
      end else begin
        sel_a_n = (e_kind[e] == 0 && e_dp[e] == 0);
        sel_b   = !(e_kind[e] == 0 && e_dp[e] == 1);
        sel_c_n = (e_kind[e] == 0 && e_dp[e] == 2);
        rd_not_wr = (e_kind[e] == 1);
        addr = AW'(e_addr[e]);
      end
      if (!e_stall[e] && k >= 2 && c_iswr[k-2]) d_in = c_wd[k-2];
      else d_in = {4'(rnd()), rnd()};
      #1;
      checks++;
      if (k < 2) begin
        if (d_oe !== 1'b0) fail("R12", "d_oe after reset", 36'(d_oe), 36'd0);
      end else begin
        string tag;
        bit xoe;
        int j = k - 2;
        xoe = c_isrd[j] && !e_oen[e];
        if (e_stall[e]) tag = "R5";
        else if (e_oen[e]) tag = "R9";
        else if (c_iswr[j]) tag = "R11";
        else tag = c_tag[j];
        if (d_oe !== xoe) fail(tag, "d_oe", 36'(d_oe), 36'(xoe));
        else if (xoe && d_out !== c_exp[j]) fail(tag, "d_out", d_out, c_exp[j]);
      end
      if (!e_stall[e]) k++;
    end
  endtask

  initial begin
    for (int a = 0; a < NW; a++) ref_m[a] = 'x;
    // R2: full write sweep, all lanes
    for (int a = 0; a < NW; a++) add(2, a, 4'h0, "R2");
    // R1: full read sweep
    for (int a = 0; a < NW; a++) add(1, a, 4'h0, "R1");
    // R10 and R8: reads one and two edges after masked writes to the same word
    for (int i = 0; i < 32; i++) begin
      add(2, i, 4'(i), "R8");
      add(1, i, 4'h0, "R10");
      add(2, i + 32, 4'(~i), "R8");
      add(2, i + 32, 4'(i * 3), "R8");
      add(1, (i + 5) % NW, 4'h0, "R1");
      add(1, i + 32, 4'h0, "R10");
      add(1, i + 32, 4'h0, "R8");
    end
    // R3: dense mix over a few words, including all deselect patterns (R4)
    for (int i = 0; i < 160; i++) begin
      logic [31:0] r = rnd();
      int kd = int'(r % 5);
      int a  = int'((r >> 4) & 7);
      logic [3:0] ln = r[12] ? r[11:8] : 4'h0;
      if (kd == 0) add(0, a, ln, "R4", int'((r >> 16) % 3));
      else if (kd <= 2) add(1, a, ln, "R3");
      else add(2, a, ln, "R3");
    end
    // R7: bursts in both orders from every start position
    for (int o = 0; o < 2; o++) begin
      g_ord = bit'(o);
      for (int s = 0; s < 4; s++) begin
        int base = 16 + 4 * s + s;
        add(2, base, 4'h0, "R7");
        for (int n = 0; n < 3; n++) add(3, 0, 4'(n == 1 ? 4'h5 : 4'h0), "R6");
        add(1, base, 4'h0, "R7");
        for (int n = 0; n < 4; n++) add(3, 0, 4'h0, "R7");
      end
    end
    g_ord = 0;
    // R6: burst after a deselect stays deselected
    add(0, 3, 4'h0, "R4", 1);
    add(3, 0, 4'h0, "R6");
    add(3, 0, 4'h0, "R6");
    // R5: stalls inside a write/read pair and inside a burst
    add(2, 40, 4'h0, "R5");
    add_stall(); add_stall();
    add(1, 40, 4'h0, "R5");
    add_stall();
    add(2, 41, 4'h2, "R5");
    add(1, 41, 4'h0, "R5");
    add_stall(); add_stall(); add_stall();
    add(1, 40, 4'h0, "R5");
    add(1, 24, 4'h0, "R5");
    add_stall();
    add(3, 0, 4'h0, "R5");
    add_stall();
    add(3, 0, 4'h0, "R5");
    // R9: output enable high over reads and a write
    add(1, 7, 4'h0, "R9");
    add(1, 8, 4'h0, "R9");
    g_oen = 1;
    add(1, 9, 4'h0, "R9");
    add(2, 9, 4'h0, "R9");
    add(1, 9, 4'h0, "R9");
    g_oen = 0;
    add(1, 9, 4'h0, "R9");
    add(0, 0, 4'h0, "R4", 2);
    add(0, 0, 4'h0, "R4", 0);
    add(0, 0, 4'h0, "R4", 1);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;   // R12: reset state before any command
    if (d_oe !== 1'b0) fail("R12", "d_oe in reset state", 36'(d_oe), 36'd0);
    run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL R3 watchdog expired: actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule